// File: doc/BRIEF.md
# Store-to-load forwarding check unit

This block sits beside the load issue path of an out-of-order core. Each issuing load is checked against a small circular store queue of older stores that are still in flight. In the cycle after issue, the load gets exactly one outcome:

- its data forwarded from a store that holds every byte it reads;
- a replay because a store overlaps it only in part;
- a reschedule because it is an uncacheable load issued too early;
- a request to the data cache.

The block keeps the store queue contents: address, size code, data, sequence number, valid and written-back flags. Separate ports allocate, write back and free entries. The block also tracks two hazards. One is a single outstanding partial-overlap stall, which is released when its store is written back. The other is the oldest load whose cache request was refused.

Top module: `ld_fwd_check`

## Requirements
- R1: An uncacheable load whose load-queue index differs from `lq_head`, or whose `ld_at_commit` is low, raises `res_resched` (with its index on `res_lq_idx`) one cycle after issue, whatever the store queue holds.
- R2: An uncacheable load at `lq_head` with `ld_at_commit` high is handled exactly like a cacheable load.
- R3: A store entry takes part in the search only if it is valid and its sequence number is below the load's. Smaller sequence numbers are older, and a freed entry is ignored. The scan walks from `ld_sq_idx` backwards around the queue. The first entry that overlaps any byte of the load decides the outcome, so the youngest older overlapping store wins.
- R4: Size codes mean 2^code bytes (0=1, 1=2, 2=4, 3=8). If the deciding store covers every byte of the load, `res_fwd` rises one cycle after issue. `res_data` then equals the store data shifted right by 8*(load address − store address) with all bytes at or above the load size zero. Store data byte 0 belongs to the store address.
- R5: If the deciding store overlaps the load only in part and is not written back, `res_replay` rises one cycle after issue. If no stall is held, `stall_valid` is set and `stall_seq`/`stall_lq_idx` record the store's sequence number and the load's index. A stall already held is kept unchanged.
- R6: A partial overlap with a store already written back causes no stall and sends the load to the cache.
- R7: A load with no deciding store raises `cache_req` one cycle after issue, with its address, size code and index.
- R8: When `cache_req` is high and `cache_ready` is low, the load is recorded in `blk_valid`/`blk_seq` on the next edge. This does not happen if a load with a smaller sequence number is already recorded.
- R9: Writing back the store whose sequence number equals `stall_seq` clears `stall_valid` and raises `wake_valid` for one cycle with the stalled load's index. Writing back any other store leaves the stall as it is.
- R10: After reset, and in any cycle that follows a cycle without issue, all result pulses are low. At most one of `res_fwd`, `res_replay`, `res_resched`, `cache_req` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| st_alloc_en | input | 1 | Write a store into an entry |
| st_alloc_idx | input | SQ_IDX_W | Entry written |
| st_alloc_seq | input | SEQ_W | Store sequence number |
| st_alloc_addr | input | ADDR_W | Store byte address |
| st_alloc_size | input | SZ_W | Store size code |
| st_alloc_data | input | DATA_W | Store data, byte 0 at the address |
| st_wb_en | input | 1 | Mark an entry written back |
| st_wb_idx | input | SQ_IDX_W | Entry written back |
| st_free_en | input | 1 | Free an entry |
| st_free_idx | input | SQ_IDX_W | Entry freed |
| ld_valid | input | 1 | Load issues this cycle |
| ld_lq_idx | input | LQ_IDX_W | Load-queue index of the load |
| ld_sq_idx | input | SQ_IDX_W | Youngest store-queue position older than the load |
| ld_seq | input | SEQ_W | Load sequence number |
| ld_addr | input | ADDR_W | Load byte address |
| ld_size | input | SZ_W | Load size code |
| ld_uncached | input | 1 | Load is uncacheable |
| ld_at_commit | input | 1 | Load has reached commit |
| lq_head | input | LQ_IDX_W | Current load-queue head |
| res_fwd | output | 1 | Forwarded data valid |
| res_data | output | DATA_W | Forwarded data |
| res_replay | output | 1 | Load must replay (partial overlap) |
| res_resched | output | 1 | Uncacheable load rescheduled |
| res_lq_idx | output | LQ_IDX_W | Index of the load the outcome belongs to |
| cache_req | output | 1 | Data cache request |
| cache_addr | output | ADDR_W | Request address |
| cache_size | output | SZ_W | Request size code |
| cache_ready | input | 1 | Cache accepts the request |
| stall_valid | output | 1 | A partial-overlap stall is held |
| stall_seq | output | SEQ_W | Sequence number of the stalling store |
| stall_lq_idx | output | LQ_IDX_W | Index of the stalled load |
| wake_valid | output | 1 | Stalled load may replay |
| wake_lq_idx | output | LQ_IDX_W | Index of the released load |
| blk_valid | output | 1 | A refused load is recorded |
| blk_seq | output | SEQ_W | Sequence number of the oldest refused load |

## Verification
The bench builds the block with a four-entry store queue, a four-entry load queue, 16-bit addresses, 8-byte data and 12-bit sequence numbers. With only four entries, a backward scan that starts at a low `ld_sq_idx` wraps past entry 0 to the top of the queue. A single scenario can therefore fill the queue with covering, partially overlapping, younger-than-load and freed entries at once. The 8-byte data width reaches every size code, so byte shifts and masks are tested from one byte up to a full doubleword.

// File: rtl/lsf_pkg.sv
package lsf_pkg;

  // Exclusive end of a byte range, one bit wider than the address.
  function automatic logic [32:0] range_end(input logic [31:0] a, input logic [3:0] code);
    return {1'b0, a} + (33'd1 << code);
  endfunction

  // True when range (sa,sc) contains every byte of range (la,lc).
  function automatic logic covers(input logic [31:0] sa, input logic [3:0] sc,
                                  input logic [31:0] la, input logic [3:0] lc);
    return (sa <= la) && (range_end(la, lc) <= range_end(sa, sc));
  endfunction

  // True when the two ranges share at least one byte.
  function automatic logic overlaps(input logic [31:0] sa, input logic [3:0] sc,
                                    input logic [31:0] la, input logic [3:0] lc);
    return ({1'b0, sa} < range_end(la, lc)) && ({1'b0, la} < range_end(sa, sc));
  endfunction

endpackage

// File: rtl/lsf_store_q.sv
module lsf_store_q #(
  parameter int SQ_DEPTH = 8,
  parameter int ADDR_W   = 32,
  parameter int SZ_W     = 2,
  parameter int DATA_W   = 64,
  parameter int SEQ_W    = 16,
  localparam int SQ_IDX_W = $clog2(SQ_DEPTH)
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                alloc_en,
  input  logic [SQ_IDX_W-1:0] alloc_idx,
  input  logic [SEQ_W-1:0]    alloc_seq,
  input  logic [ADDR_W-1:0]   alloc_addr,
  input  logic [SZ_W-1:0]     alloc_size,
  input  logic [DATA_W-1:0]   alloc_data,
  input  logic                wb_en,
  input  logic [SQ_IDX_W-1:0] wb_idx,
  input  logic                free_en,
  input  logic [SQ_IDX_W-1:0] free_idx,
  output logic                q_valid [SQ_DEPTH],
  output logic                q_wb    [SQ_DEPTH],
  output logic [SEQ_W-1:0]    q_seq   [SQ_DEPTH],
  output logic [ADDR_W-1:0]   q_addr  [SQ_DEPTH],
  output logic [SZ_W-1:0]     q_size  [SQ_DEPTH],
  output logic [DATA_W-1:0]   q_data  [SQ_DEPTH]
);

  for (genvar i = 0; i < SQ_DEPTH; i++) begin : g_ent
    always_ff @(posedge clk) begin
      if (!rst_n) begin
        q_valid[i] <= 1'b0;
        q_wb[i]    <= 1'b0;
        q_seq[i]   <= '0;
        q_addr[i]  <= '0;
        q_size[i]  <= '0;
        q_data[i]  <= '0;
      end else if (alloc_en && alloc_idx == SQ_IDX_W'(i)) begin
        q_valid[i] <= 1'b1;
        q_wb[i]    <= 1'b0;
        q_seq[i]   <= alloc_seq;
        q_addr[i]  <= alloc_addr;
        q_size[i]  <= alloc_size;
        q_data[i]  <= alloc_data;
      end else begin
        if (wb_en && wb_idx == SQ_IDX_W'(i))     q_wb[i]    <= 1'b1;
        if (free_en && free_idx == SQ_IDX_W'(i)) q_valid[i] <= 1'b0;
      end
    end
  end

endmodule

// File: rtl/lsf_search.sv
module lsf_search #(
  parameter int SQ_DEPTH   = 8,
  parameter int ADDR_W     = 32,
  parameter int SZ_W       = 2,
  parameter int DATA_BYTES = 8,
  parameter int SEQ_W      = 16,
  localparam int SQ_IDX_W  = $clog2(SQ_DEPTH),
  localparam int DATA_W    = DATA_BYTES * 8,
  localparam int OFF_W     = $clog2(DATA_BYTES)
) (
  input  logic                q_valid [SQ_DEPTH],
  input  logic                q_wb    [SQ_DEPTH],
  input  logic [SEQ_W-1:0]    q_seq   [SQ_DEPTH],
  input  logic [ADDR_W-1:0]   q_addr  [SQ_DEPTH],
  input  logic [SZ_W-1:0]     q_size  [SQ_DEPTH],
  input  logic [DATA_W-1:0]   q_data  [SQ_DEPTH],
  input  logic [SQ_IDX_W-1:0] ld_sq_idx,
  input  logic [SEQ_W-1:0]    ld_seq,
  input  logic [ADDR_W-1:0]   ld_addr,
  input  logic [SZ_W-1:0]     ld_size,
  output logic                hit,
  output logic                hit_full,
  output logic                hit_wb,
  output logic [SEQ_W-1:0]    hit_seq,
  output logic [DATA_W-1:0]   fwd_data
);

  // Shift store data down to the load's first byte and clear bytes past its size.
  function automatic logic [DATA_W-1:0] align_data(input logic [DATA_W-1:0] d,
                                                   input logic [OFF_W-1:0] off,
                                                   input logic [SZ_W-1:0] code);
    logic [DATA_W-1:0] sh;
    logic [DATA_W-1:0] mask;
    sh   = d >> {off, 3'b000};
    mask = '0;
    for (int b = 0; b < DATA_BYTES; b++)
      if (b < (1 << code)) mask[b*8 +: 8] = 8'hFF;
    return sh & mask;
  endfunction

  logic [SQ_IDX_W-1:0] sel;

  // Backward scan from the load's store position; nearest overlapping older store decides.
  always_comb begin
    logic [SQ_IDX_W-1:0] scan;
    hit = 1'b0;
    sel = '0;
    for (int d = 0; d < SQ_DEPTH; d++) begin
      scan = ld_sq_idx - SQ_IDX_W'(d);
      if (!hit && q_valid[scan] && (q_seq[scan] < ld_seq) &&
          lsf_pkg::overlaps(32'(q_addr[scan]), 4'(q_size[scan]), 32'(ld_addr), 4'(ld_size))) begin
        hit = 1'b1;
        sel = scan;
      end
    end
  end

  assign hit_full = hit && lsf_pkg::covers(32'(q_addr[sel]), 4'(q_size[sel]),
                                           32'(ld_addr), 4'(ld_size));
  assign hit_wb   = q_wb[sel];
  assign hit_seq  = q_seq[sel];
  assign fwd_data = align_data(q_data[sel], OFF_W'(ld_addr - q_addr[sel]), ld_size);

endmodule

// File: rtl/lsf_hazard_trk.sv
module lsf_hazard_trk #(
  parameter int SEQ_W    = 16,
  parameter int LQ_IDX_W = 3
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                stall_set,
  input  logic [SEQ_W-1:0]    stall_store_seq,
  input  logic [LQ_IDX_W-1:0] stall_load_idx,
  input  logic                wb_en,
  input  logic [SEQ_W-1:0]    wb_seq,
  input  logic                refuse_en,
  input  logic [SEQ_W-1:0]    refuse_seq,
  output logic                stall_valid,
  output logic [SEQ_W-1:0]    stall_seq,
  output logic [LQ_IDX_W-1:0] stall_lq_idx,
  output logic                wake_valid,
  output logic [LQ_IDX_W-1:0] wake_lq_idx,
  output logic                blk_valid,
  output logic [SEQ_W-1:0]    blk_seq
);

  logic release_ev;
  logic record_blk;

  assign release_ev = stall_valid && wb_en && (wb_seq == stall_seq);
  assign record_blk = refuse_en && (!blk_valid || refuse_seq < blk_seq);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      stall_valid  <= 1'b0;
      stall_seq    <= '0;
      stall_lq_idx <= '0;
      wake_valid   <= 1'b0;
      wake_lq_idx  <= '0;
    end else begin
      wake_valid <= release_ev;
      if (release_ev) begin
        stall_valid <= 1'b0;
        wake_lq_idx <= stall_lq_idx;
      end else if (!stall_valid && stall_set) begin
        stall_valid  <= 1'b1;
        stall_seq    <= stall_store_seq;
        stall_lq_idx <= stall_load_idx;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      blk_valid <= 1'b0;
      blk_seq   <= '0;
    end else if (record_blk) begin
      blk_valid <= 1'b1;
      blk_seq   <= refuse_seq;
    end
  end

  // R9: a wake pulse follows the stall being dropped
  p_wake_on_release_r9: assert property (@(posedge clk) disable iff (!rst_n)
    wake_valid |-> (!stall_valid && $past(stall_valid)));

  // R5: a held stall keeps its recorded store
  p_stall_held_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (stall_valid && $past(stall_valid)) |-> (stall_seq == $past(stall_seq)));

  // R8: the recorded blocked load never becomes younger
  p_blk_oldest_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (blk_valid && $past(blk_valid)) |-> (blk_seq <= $past(blk_seq)));

endmodule

// File: rtl/ld_fwd_check.sv
module ld_fwd_check #(
  parameter int SQ_DEPTH   = 8,
  parameter int LQ_DEPTH   = 8,
  parameter int ADDR_W     = 32,
  parameter int DATA_BYTES = 8,
  parameter int SEQ_W      = 16,
  localparam int SQ_IDX_W  = $clog2(SQ_DEPTH),
  localparam int LQ_IDX_W  = $clog2(LQ_DEPTH),
  localparam int DATA_W    = DATA_BYTES * 8,
  localparam int SZ_W      = $clog2($clog2(DATA_BYTES) + 1)
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                st_alloc_en,
  input  logic [SQ_IDX_W-1:0] st_alloc_idx,
  input  logic [SEQ_W-1:0]    st_alloc_seq,
  input  logic [ADDR_W-1:0]   st_alloc_addr,
  input  logic [SZ_W-1:0]     st_alloc_size,
  input  logic [DATA_W-1:0]   st_alloc_data,
  input  logic                st_wb_en,
  input  logic [SQ_IDX_W-1:0] st_wb_idx,
  input  logic                st_free_en,
  input  logic [SQ_IDX_W-1:0] st_free_idx,
  input  logic                ld_valid,
  input  logic [LQ_IDX_W-1:0] ld_lq_idx,
  input  logic [SQ_IDX_W-1:0] ld_sq_idx,
  input  logic [SEQ_W-1:0]    ld_seq,
  input  logic [ADDR_W-1:0]   ld_addr,
  input  logic [SZ_W-1:0]     ld_size,
  input  logic                ld_uncached,
  input  logic                ld_at_commit,
  input  logic [LQ_IDX_W-1:0] lq_head,
  output logic                res_fwd,
  output logic [DATA_W-1:0]   res_data,
  output logic                res_replay,
  output logic                res_resched,
  output logic [LQ_IDX_W-1:0] res_lq_idx,
  output logic                cache_req,
  output logic [ADDR_W-1:0]   cache_addr,
  output logic [SZ_W-1:0]     cache_size,
  input  logic                cache_ready,
  output logic                stall_valid,
  output logic [SEQ_W-1:0]    stall_seq,
  output logic [LQ_IDX_W-1:0] stall_lq_idx,
  output logic                wake_valid,
  output logic [LQ_IDX_W-1:0] wake_lq_idx,
  output logic                blk_valid,
  output logic [SEQ_W-1:0]    blk_seq
);

  logic                q_valid [SQ_DEPTH];
  logic                q_wb    [SQ_DEPTH];
  logic [SEQ_W-1:0]    q_seq   [SQ_DEPTH];
  logic [ADDR_W-1:0]   q_addr  [SQ_DEPTH];
  logic [SZ_W-1:0]     q_size  [SQ_DEPTH];
  logic [DATA_W-1:0]   q_data  [SQ_DEPTH];

  lsf_store_q #(.SQ_DEPTH(SQ_DEPTH), .ADDR_W(ADDR_W), .SZ_W(SZ_W),
                .DATA_W(DATA_W), .SEQ_W(SEQ_W)) u_sq (
    .clk(clk), .rst_n(rst_n),
    .alloc_en(st_alloc_en), .alloc_idx(st_alloc_idx), .alloc_seq(st_alloc_seq),
    .alloc_addr(st_alloc_addr), .alloc_size(st_alloc_size), .alloc_data(st_alloc_data),
    .wb_en(st_wb_en), .wb_idx(st_wb_idx), .free_en(st_free_en), .free_idx(st_free_idx),
    .q_valid(q_valid), .q_wb(q_wb), .q_seq(q_seq), .q_addr(q_addr),
    .q_size(q_size), .q_data(q_data)
  );

  logic              hit, hit_full, hit_wb;
  logic [SEQ_W-1:0]  hit_seq;
  logic [DATA_W-1:0] fwd_data;

  lsf_search #(.SQ_DEPTH(SQ_DEPTH), .ADDR_W(ADDR_W), .SZ_W(SZ_W),
               .DATA_BYTES(DATA_BYTES), .SEQ_W(SEQ_W)) u_search (
    .q_valid(q_valid), .q_wb(q_wb), .q_seq(q_seq), .q_addr(q_addr),
    .q_size(q_size), .q_data(q_data),
    .ld_sq_idx(ld_sq_idx), .ld_seq(ld_seq), .ld_addr(ld_addr), .ld_size(ld_size),
    .hit(hit), .hit_full(hit_full), .hit_wb(hit_wb), .hit_seq(hit_seq), .fwd_data(fwd_data)
  );

  // Outcome selection, brought out as named events.
  logic uc_reject, take_resched, take_fwd, take_replay, take_cache;
  assign uc_reject    = ld_uncached && (ld_lq_idx != lq_head || !ld_at_commit);
  assign take_resched = ld_valid && uc_reject;
  assign take_fwd     = ld_valid && !uc_reject && hit && hit_full;
  assign take_replay  = ld_valid && !uc_reject && hit && !hit_full && !hit_wb;
  assign take_cache   = ld_valid && !uc_reject && !take_fwd && !take_replay;

  logic [SEQ_W-1:0] cache_seq;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      res_fwd     <= 1'b0;
      res_replay  <= 1'b0;
      res_resched <= 1'b0;
      cache_req   <= 1'b0;
      res_data    <= '0;
      res_lq_idx  <= '0;
      cache_addr  <= '0;
      cache_size  <= '0;
      cache_seq   <= '0;
    end else begin
      res_fwd     <= take_fwd;
      res_replay  <= take_replay;
      res_resched <= take_resched;
      cache_req   <= take_cache;
      res_data    <= take_fwd ? fwd_data : '0;
      if (ld_valid) begin
        res_lq_idx <= ld_lq_idx;
        cache_addr <= ld_addr;
        cache_size <= ld_size;
        cache_seq  <= ld_seq;
      end
    end
  end

  lsf_hazard_trk #(.SEQ_W(SEQ_W), .LQ_IDX_W(LQ_IDX_W)) u_haz (
    .clk(clk), .rst_n(rst_n),
    .stall_set(take_replay), .stall_store_seq(hit_seq), .stall_load_idx(ld_lq_idx),
    .wb_en(st_wb_en), .wb_seq(q_seq[st_wb_idx]),
    .refuse_en(cache_req && !cache_ready), .refuse_seq(cache_seq),
    .stall_valid(stall_valid), .stall_seq(stall_seq), .stall_lq_idx(stall_lq_idx),
    .wake_valid(wake_valid), .wake_lq_idx(wake_lq_idx),
    .blk_valid(blk_valid), .blk_seq(blk_seq)
  );

  // R10: never more than one outcome in a cycle
  p_one_outcome_r10: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({res_fwd, res_replay, res_resched, cache_req}));

  // R10: no outcome without an issue in the previous cycle
  p_quiet_r10: assert property (@(posedge clk) disable iff (!rst_n)
    !ld_valid |=> !(res_fwd || res_replay || res_resched || cache_req));

  // R1: an uncacheable load not yet at commit is rescheduled
  p_resched_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (ld_valid && ld_uncached && !ld_at_commit) |=> res_resched);

  // R5: a new stall only appears together with a replay
  p_stall_with_replay_r5: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(stall_valid) |-> res_replay);

endmodule

// File: tb/test_ld_fwd_check.sv
`timescale 1ns/1ps
module test_ld_fwd_check;

  localparam int SQD = 4, LQD = 4, AW = 16, DB = 8, SW = 12;
  localparam int K_FWD = 1, K_REPLAY = 2, K_RESCHED = 3, K_CACHE = 4;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #10 clk = ~clk;

  logic st_alloc_en = 0; logic [1:0] st_alloc_idx = 0; logic [SW-1:0] st_alloc_seq = 0;
  logic [AW-1:0] st_alloc_addr = 0; logic [1:0] st_alloc_size = 0; logic [63:0] st_alloc_data = 0;
  logic st_wb_en = 0; logic [1:0] st_wb_idx = 0; logic st_free_en = 0; logic [1:0] st_free_idx = 0;
  logic ld_valid = 0; logic [1:0] ld_lq_idx = 0; logic [1:0] ld_sq_idx = 0; logic [SW-1:0] ld_seq = 0;
  logic [AW-1:0] ld_addr = 0; logic [1:0] ld_size = 0; logic ld_uncached = 0; logic ld_at_commit = 0;
  logic [1:0] lq_head = 0; logic cache_ready = 1;
  logic res_fwd, res_replay, res_resched, cache_req, stall_valid, wake_valid, blk_valid;
  logic [63:0] res_data; logic [1:0] res_lq_idx, stall_lq_idx, wake_lq_idx;
  logic [AW-1:0] cache_addr; logic [1:0] cache_size; logic [SW-1:0] stall_seq, blk_seq;

  ld_fwd_check #(.SQ_DEPTH(SQD), .LQ_DEPTH(LQD), .ADDR_W(AW), .DATA_BYTES(DB), .SEQ_W(SW)) i_ld_fwd_check (
    .clk(clk), .rst_n(rst_n),
    .st_alloc_en(st_alloc_en), .st_alloc_idx(st_alloc_idx), .st_alloc_seq(st_alloc_seq),
    .st_alloc_addr(st_alloc_addr), .st_alloc_size(st_alloc_size), .st_alloc_data(st_alloc_data),
    .st_wb_en(st_wb_en), .st_wb_idx(st_wb_idx), .st_free_en(st_free_en), .st_free_idx(st_free_idx),
    .ld_valid(ld_valid), .ld_lq_idx(ld_lq_idx), .ld_sq_idx(ld_sq_idx), .ld_seq(ld_seq),
    .ld_addr(ld_addr), .ld_size(ld_size), .ld_uncached(ld_uncached), .ld_at_commit(ld_at_commit),
    .lq_head(lq_head), .res_fwd(res_fwd), .res_data(res_data), .res_replay(res_replay),
    .res_resched(res_resched), .res_lq_idx(res_lq_idx), .cache_req(cache_req),
    .cache_addr(cache_addr), .cache_size(cache_size), .cache_ready(cache_ready),
    .stall_valid(stall_valid), .stall_seq(stall_seq), .stall_lq_idx(stall_lq_idx),
    .wake_valid(wake_valid), .wake_lq_idx(wake_lq_idx), .blk_valid(blk_valid), .blk_seq(blk_seq));

  int n_checks = 0, n_errors = 0;
  task automatic check(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
    n_checks++;
    if (!ok) begin
      n_errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // Bench-side model of store queue contents (stimulus mirror).
  bit m_valid [SQD]; bit m_wb [SQD]; int m_seq [SQD]; int m_addr [SQD]; int m_code [SQD];
  logic [63:0] m_data [SQD];
  bit m_stall = 0; int m_stall_seq = 0; int m_stall_lq = 0;

  typedef struct { int kind; logic [63:0] data; int lq; int addr; int code; string tag; } exp_t;
  exp_t exp_q[$];

  task automatic sq_alloc(input int i, input int seq, input int addr, input int code, input logic [63:0] d);
    @(negedge clk);
    st_alloc_en = 1; st_alloc_idx = 2'(i); st_alloc_seq = SW'(seq);
    st_alloc_addr = AW'(addr); st_alloc_size = 2'(code); st_alloc_data = d;
    m_valid[i] = 1; m_wb[i] = 0; m_seq[i] = seq; m_addr[i] = addr; m_code[i] = code; m_data[i] = d;
    @(negedge clk);
    st_alloc_en = 0;
  endtask

  task automatic sq_wb(input int i);
    @(negedge clk);
    st_wb_en = 1; st_wb_idx = 2'(i); m_wb[i] = 1;
    @(negedge clk);
    st_wb_en = 0;
  endtask

  task automatic sq_free(input int i);
    @(negedge clk);
    st_free_en = 1; st_free_idx = 2'(i); m_valid[i] = 0;
    @(negedge clk);
    st_free_en = 0;
  endtask

  // Expected outcome: youngest older store touching any load byte decides.
  task automatic predict(input int seq, input int addr, input int code, input bit unc,
                         input bit commit, input int lq, input int head,
                         output exp_t e, output int st_seq);
    int best = -1;
    int lb = 1 << code;
    e.kind = K_CACHE; e.data = 0; e.lq = lq; e.addr = addr; e.code = code; st_seq = 0;
    if (unc && (lq != head || !commit)) begin e.kind = K_RESCHED; return; end
    for (int j = 0; j < SQD; j++) begin
      bit ovl = 0;
      if (m_valid[j] && m_seq[j] < seq)
        for (int b = 0; b < lb; b++)
          if (addr + b >= m_addr[j] && addr + b < m_addr[j] + (1 << m_code[j])) ovl = 1;
      if (ovl && (best < 0 || m_seq[j] > m_seq[best])) best = j;
    end
    if (best < 0) return;
    begin
      bit full = 1;
      for (int b = 0; b < lb; b++)
        if (addr + b >= m_addr[best] + (1 << m_code[best])) full = 0;
      if (addr < m_addr[best]) full = 0;
      st_seq = m_seq[best];
      if (full) begin
        e.kind = K_FWD;
        for (int b = 0; b < lb; b++) e.data[b*8 +: 8] = m_data[best][(addr + b - m_addr[best])*8 +: 8];
      end else if (!m_wb[best]) e.kind = K_REPLAY;
    end
  endtask

  task automatic do_load(input int lq, input int sqi, input int seq, input int addr, input int code,
                         input bit unc, input bit commit, input int head, input string tag);
    exp_t e; int sseq;
    predict(seq, addr, code, unc, commit, lq, head, e, sseq);
    e.tag = tag;
    if (e.kind == K_REPLAY && !m_stall) begin m_stall = 1; m_stall_seq = sseq; m_stall_lq = lq; end
    @(negedge clk);
    exp_q.push_back(e);
    ld_valid = 1; ld_lq_idx = 2'(lq); ld_sq_idx = 2'(sqi); ld_seq = SW'(seq); ld_addr = AW'(addr);
    ld_size = 2'(code); ld_uncached = unc; ld_at_commit = commit; lq_head = 2'(head);
    @(negedge clk);
    ld_valid = 0; ld_uncached = 0;
    #2;
    check(exp_q.size() == 0, {tag, " outcome missing"}, 64'(exp_q.size()), 0);
    exp_q.delete();
  endtask

  // Monitor: pops an expected item whenever the design reports an outcome.
  always @(negedge clk) begin
    if (rst_n && (res_fwd || res_replay || res_resched || cache_req)) begin
      int ak;
      ak = res_fwd ? K_FWD : res_replay ? K_REPLAY : res_resched ? K_RESCHED : K_CACHE;
      if (exp_q.size() == 0) check(0, "R10 unexpected outcome", 64'(ak), 0);
      else begin
        exp_t e;
        e = exp_q.pop_front();
        check(ak == e.kind && $onehot({res_fwd, res_replay, res_resched, cache_req}),
              {e.tag, " kind"}, 64'(ak), 64'(e.kind));
        check(res_lq_idx == 2'(e.lq), {e.tag, " lq idx"}, 64'(res_lq_idx), 64'(e.lq));
        if (e.kind == K_FWD) check(res_data == e.data, {e.tag, " data"}, res_data, e.data);
        if (e.kind == K_CACHE) begin
          check(cache_addr == AW'(e.addr), {e.tag, " cache addr"}, 64'(cache_addr), 64'(e.addr));
          check(cache_size == 2'(e.code), {e.tag, " cache size"}, 64'(cache_size), 64'(e.code));
        end
      end
    end
  end

  task automatic check_stall(input string tag);
    check(stall_valid == m_stall, {tag, " stall_valid"}, 64'(stall_valid), 64'(m_stall));
    if (m_stall) begin
      check(stall_seq == SW'(m_stall_seq), {tag, " stall_seq"}, 64'(stall_seq), 64'(m_stall_seq));
      check(stall_lq_idx == 2'(m_stall_lq), {tag, " stall_lq_idx"}, 64'(stall_lq_idx), 64'(m_stall_lq));
    end
  endtask

  task automatic refused_load(input int lq, input int seq, input int exp_blk, input string tag);
    cache_ready = 0;
    do_load(lq, 2, seq, 'h300, 3, 0, 0, 0, tag);
    @(negedge clk);
    cache_ready = 1;
    check(blk_valid == 1'b1, {tag, " blk_valid"}, 64'(blk_valid), 1);
    check(blk_seq == SW'(exp_blk), {tag, " blk_seq"}, 64'(blk_seq), 64'(exp_blk));
  endtask

  bit done = 0;
  initial begin
    #2000000;
    if (!done) begin
      n_checks++; n_errors++;
      $display("FAIL watchdog expired");
      $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
      $finish;
    end
  end

  initial begin
    for (int j = 0; j < SQD; j++) begin m_valid[j] = 0; m_wb[j] = 0; end
    repeat (3) @(negedge clk);
    // R10: reset state
    check(!(res_fwd || res_replay || res_resched || cache_req), "R10 reset outcomes", 0, 0);
    check(!stall_valid && !wake_valid && !blk_valid, "R10 reset hazards", 0, 0);
    rst_n = 1;
    sq_alloc(0, 10, 'h100, 3, 64'h8877665544332211);
    sq_alloc(1, 12, 'h104, 1, 64'h000000000000BBAA);
    sq_alloc(2, 14, 'h200, 2, 64'h00000000DDCCBBAA);
    sq_alloc(3, 8,  'h400, 3, 64'h0F0E0D0C0B0A0908);
    do_load(0, 2, 20, 'h104, 1, 0, 0, 0, "R4 full cover halfword");
    do_load(1, 1, 20, 'h104, 0, 0, 0, 0, "R3 youngest older wins");
    do_load(2, 0, 11, 'h104, 1, 0, 0, 0, "R3 younger store skipped");
    do_load(3, 1, 40, 'h402, 1, 0, 0, 0, "R3 wrapped scan");
    do_load(0, 1, 40, 'h404, 2, 0, 0, 0, "R4 word shift");
    do_load(1, 1, 40, 'h400, 3, 0, 0, 0, "R4 full doubleword");
    do_load(3, 2, 20, 'h102, 2, 0, 0, 0, "R5 partial overlap");
    check_stall("R5 stall recorded");
    do_load(2, 2, 22, 'h1FE, 2, 0, 0, 0, "R5 second partial");
    check_stall("R5 stall kept");
    sq_wb(0);
    check(!wake_valid, "R9 other store no wake", 64'(wake_valid), 0);
    check_stall("R9 other store keeps stall");
    sq_wb(1);
    m_stall = 0;
    check(wake_valid == 1'b1, "R9 wake pulse", 64'(wake_valid), 1);
    check(wake_lq_idx == 2'd3, "R9 wake lq idx", 64'(wake_lq_idx), 3);
    check_stall("R9 stall cleared");
    @(negedge clk);
    check(!wake_valid, "R9 wake single cycle", 64'(wake_valid), 0);
    do_load(0, 2, 20, 'h103, 1, 0, 0, 0, "R6 partial written back");
    check_stall("R6 no stall");
    do_load(1, 2, 30, 'h300, 3, 0, 0, 0, "R7 no overlap");
    check(!blk_valid, "R8 accepted not blocked", 64'(blk_valid), 0);
    refused_load(1, 30, 30, "R8 first refusal");
    refused_load(2, 35, 30, "R8 younger refusal ignored");
    refused_load(3, 25, 25, "R8 older refusal replaces");
    sq_free(2);
    do_load(0, 2, 30, 'h200, 2, 0, 0, 0, "R3 freed entry ignored");
    do_load(1, 1, 40, 'h402, 1, 1, 1, 0, "R1 uncached not at head");
    do_load(0, 1, 40, 'h402, 1, 1, 0, 0, "R1 uncached not at commit");
    do_load(0, 1, 40, 'h406, 1, 1, 1, 0, "R2 uncached at head forwards");
    do_load(2, 1, 40, 'h600, 0, 1, 1, 2, "R2 uncached at head to cache");
    @(negedge clk);
    check(!(res_fwd || res_replay || res_resched || cache_req), "R10 idle", 0, 0);
    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
    $finish;
  end

endmodule